// File: doc/BRIEF.md
# Gated Integer Clock Divider with Programmable High Time

This block derives a slower square-ish wave from its input clock. Two configuration fields, both `FIELD_W` bits wide, are held in registers loaded through a single write strobe. The divide field sets the output period. A value `val` of one or more gives a period of `val+1` input cycles. A value of zero stops the output, which then stays low. The high-time field `hi` sets how many cycles of each period the output is high: `hi+1` cycles, so the duty is `(hi+1)/(val+1)`.

A new setting only takes effect at the end of the period in progress, so the output never shows a shortened pulse. This holds for a new ratio, a new duty, or a request to stop. When the output is started from the stopped state, it begins a fresh period with its high phase. An enable-status output reports whether the divide field currently holds a nonzero value.

The block sits beside a clock tree as the divider stage of a sample-rate clock. It contains no bus logic and no rate search.

Top module: `sdiv_gen`

## Requirements
- R1: A synchronous reset clears both configuration fields to zero. On the cycle after reset, `div_enabled` is 0 and `div_clk` is 0.
- R2: `div_enabled` is 1 exactly when the stored divide field is nonzero. It follows a write on the cycle after the write edge.
- R3: While the divide field is zero and any period in progress has finished, `div_clk` is held low and produces no edges.
- R4: With a divide field `val` of 1 or more, each output period lasts `val+1` input cycles.
- R5: With `hi <= val`, `div_clk` is high for `hi+1` cycles and then low for `val-hi` cycles of each period. `hi == val` therefore keeps the output constantly high.
- R6: With `hi > val`, the high time is clamped to `val` cycles, so the output is low for exactly one cycle per period.
- R7: The divide range runs from ratio 2 (field value 1) up to ratio `2^FIELD_W` (field all ones).
- R8: New field values are adopted only when the running period ends. The period in progress completes with its old high time and length, whether the new value changes the ratio or is zero.
- R9: Starting from the stopped state, `div_clk` rises two rising edges after the edge that stores a nonzero divide field. The high phase comes first.
- R10: Field inputs presented while `cfg_we` is 0 are ignored: the status and the output do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write strobe that loads both fields |
| cfg_div | input | FIELD_W | Divide field value (0 stops the output) |
| cfg_high | input | FIELD_W | High-time field value |
| div_enabled | output | 1 | High while the stored divide field is nonzero |
| div_clk | output | 1 | Divided output wave |

## Verification
Several properties are checked on every cycle:
- The period counter never passes the adopted divide value.
- The adopted settings stay fixed until the counter reaches its last count.
- A start always begins at count zero.
- The effective high time never exceeds the divide value.
- A stopped divider gives a low output.
- Fields do not move without a write.
- Reset clears everything.

The exact high and low lengths for each ratio and duty, the clamp for an oversize high field, the two-edge start latency, and the completion of a period that is interrupted by a new setting or a stop request can only be shown by the bench's scenarios, which measure the output wave period by period.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

    // Run state of the period counter
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

endpackage

// File: rtl/sdiv_cfg.sv
module sdiv_cfg #(
    parameter int FIELD_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [FIELD_W-1:0] div_in,
    input  logic [FIELD_W-1:0] hi_in,
    output logic [FIELD_W-1:0] div_o,
    output logic [FIELD_W-1:0] hi_o,
    output logic               en_o
);

    typedef struct packed {
        logic [FIELD_W-1:0] dv;
        logic [FIELD_W-1:0] hv;
    } cfg_s;

    cfg_s cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d.dv = div_in;
            cfg_d.hv = hi_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= cfg_d;
    end

    assign div_o = cfg_q.dv;
    assign hi_o  = cfg_q.hv;
    assign en_o  = (cfg_q.dv != '0);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (cfg_q == '0) && !en_o); // R1

    AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(cfg_q)); // R10

endmodule

// File: rtl/sdiv_core.sv
module sdiv_core
    import sdiv_pkg::*;
#(
    parameter int FIELD_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [FIELD_W-1:0] div_f,
    input  logic [FIELD_W-1:0] hi_f,
    output logic               run_o,
    output logic [FIELD_W-1:0] cnt_o,
    output logic [FIELD_W-1:0] hv_o
);

    localparam logic [FIELD_W-1:0] ONE = FIELD_W'(1);

    typedef struct packed {
        phase_e             ph;
        logic [FIELD_W-1:0] cnt;
        logic [FIELD_W-1:0] dv;
        logic [FIELD_W-1:0] hv;
    } core_s;

    core_s core_d, core_q;
    logic  last_cnt;
    logic  adopt;

    always_comb begin
        core_d   = core_q;
        last_cnt = (core_q.ph == PH_RUN) && (core_q.cnt == core_q.dv);
        adopt    = (core_q.ph == PH_IDLE) || last_cnt;
        if (adopt) begin
            core_d.cnt = '0;
            if (div_f != '0) begin
                core_d.ph = PH_RUN;
                core_d.dv = div_f;
                core_d.hv = (hi_f > div_f) ? (div_f - ONE) : hi_f;
            end else begin
                core_d.ph = PH_IDLE;
            end
        end else begin
            core_d.cnt = core_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core_q.ph  <= PH_IDLE;
            core_q.cnt <= '0;
            core_q.dv  <= '0;
            core_q.hv  <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign run_o = (core_q.ph == PH_RUN);
    assign cnt_o = core_q.cnt;
    assign hv_o  = core_q.hv;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        run_o |-> (core_q.cnt <= core_q.dv) && (core_q.dv != '0)); // R4

    AST_HI_CLAMP: assert property (@(posedge clk) disable iff (rst)
        run_o |-> (core_q.hv <= core_q.dv)); // R6

    AST_HOLD_SETTINGS: assert property (@(posedge clk) disable iff (rst)
        (run_o && (core_q.cnt != core_q.dv)) |=>
            $stable(core_q.dv) && $stable(core_q.hv) && run_o); // R8

    AST_FRESH_START: assert property (@(posedge clk) disable iff (rst)
        $rose(run_o) |-> (core_q.cnt == '0)); // R9

endmodule

// File: rtl/sdiv_wave.sv
module sdiv_wave #(
    parameter int FIELD_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run_i,
    input  logic [FIELD_W-1:0] cnt_i,
    input  logic [FIELD_W-1:0] hv_i,
    output logic               wave_o
);

    typedef struct packed {
        logic lvl;
    } wave_s;

    wave_s wave_d, wave_q;

    always_comb begin
        wave_d.lvl = run_i && (cnt_i <= hv_i);
    end

    always_ff @(posedge clk) begin
        if (rst) wave_q <= '0;
        else     wave_q <= wave_d;
    end

    assign wave_o = wave_q.lvl;

    AST_GATED_LOW: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> !wave_o); // R3

    AST_HIGH_AT_START: assert property (@(posedge clk) disable iff (rst)
        (run_i && (cnt_i == '0)) |=> wave_o); // R9

endmodule

// File: rtl/sdiv_gen.sv
module sdiv_gen #(
    parameter int FIELD_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [FIELD_W-1:0] cfg_div,
    input  logic [FIELD_W-1:0] cfg_high,
    output logic               div_enabled,
    output logic               div_clk
);

    logic [FIELD_W-1:0] fld_div;
    logic [FIELD_W-1:0] fld_hi;
    logic               run_w;
    logic [FIELD_W-1:0] cnt_w;
    logic [FIELD_W-1:0] hv_w;

    sdiv_cfg #(.FIELD_W(FIELD_W)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .div_in (cfg_div),
        .hi_in  (cfg_high),
        .div_o  (fld_div),
        .hi_o   (fld_hi),
        .en_o   (div_enabled)
    );

    sdiv_core #(.FIELD_W(FIELD_W)) u_core (
        .clk   (clk),
        .rst   (rst),
        .div_f (fld_div),
        .hi_f  (fld_hi),
        .run_o (run_w),
        .cnt_o (cnt_w),
        .hv_o  (hv_w)
    );

    sdiv_wave #(.FIELD_W(FIELD_W)) u_wave (
        .clk    (clk),
        .rst    (rst),
        .run_i  (run_w),
        .cnt_i  (cnt_w),
        .hv_i   (hv_w),
        .wave_o (div_clk)
    );

    AST_STATUS_MATCH: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && (cfg_div != '0)) |=> div_enabled); // R2

endmodule

// File: tb/sim_sdiv_gen.sv
module sim_sdiv_gen;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_we = 1'b0;
    logic [W-1:0] cfg_div = '0;
    logic [W-1:0] cfg_high = '0;
    logic         div_enabled;
    logic         div_clk;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // div, high, expected high cycles, expected period
    localparam int NV = 8;
    localparam int VEC [NV][4] = '{
        '{1,   0,   1,   2},   // R7 smallest ratio
        '{1,   5,   1,   2},   // R6 clamp at ratio 2
        '{3,   1,   2,   4},   // R5
        '{5,   2,   3,   6},   // R5
        '{4,   7,   4,   5},   // R6 clamp
        '{255, 0,   1,   256}, // R7 largest ratio
        '{255, 254, 255, 256}, // R5
        '{7,   0,   1,   8}    // R4
    };

    sdiv_gen #(.FIELD_W(W)) u0 (
        .clk         (clk),
        .rst         (rst),
        .cfg_we      (cfg_we),
        .cfg_div     (cfg_div),
        .cfg_high    (cfg_high),
        .div_enabled (div_enabled),
        .div_clk     (div_clk)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    // leaves the caller at the negedge after the write edge
    task automatic wr(input int d, input int h);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_div  = W'(d);
        cfg_high = W'(h);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_high();
        int g = 0;
        while (div_clk !== 1'b1 && g < 600) begin
            @(negedge clk);
            g++;
        end
    endtask

    // called at a negedge with div_clk high, pre high cycles already seen
    task automatic measure(input int pre, output int h, output int p);
        int g = 0;
        int l = 0;
        h = pre;
        @(negedge clk);
        while (div_clk === 1'b1 && g < 600) begin
            h++; g++;
            @(negedge clk);
        end
        while (div_clk === 1'b0 && g < 600) begin
            l++; g++;
            @(negedge clk);
        end
        p = h + l;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int h, p;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset status", int'(div_enabled), 0);
        check("R1 reset output", int'(div_clk), 0);

        // R10: inputs without strobe ignored
        @(negedge clk);
        cfg_div = 8'd5;
        cfg_high = 8'd1;
        repeat (6) @(negedge clk);
        check("R10 status unchanged", int'(div_enabled), 0);
        check("R10 output unchanged", int'(div_clk), 0);

        for (int i = 0; i < NV; i++) begin
            do_reset();
            wr(VEC[i][0], VEC[i][1]);
            check($sformatf("R2 status v%0d", i), int'(div_enabled), 1);
            check($sformatf("R9 low after write v%0d", i), int'(div_clk), 0);
            @(negedge clk);
            check($sformatf("R9 low one edge later v%0d", i), int'(div_clk), 0);
            @(negedge clk);
            check($sformatf("R9 high second edge v%0d", i), int'(div_clk), 1);
            measure(1, h, p);
            check($sformatf("R5 high len v%0d", i), h, VEC[i][2]);
            check($sformatf("R4 period v%0d", i), p, VEC[i][3]);
            measure(1, h, p);
            check($sformatf("R5 high len again v%0d", i), h, VEC[i][2]);
            check($sformatf("R4 period again v%0d", i), p, VEC[i][3]);
        end

        // R5: hi equal to val gives a constant high level
        do_reset();
        wr(3, 3);
        wait_high();
        h = 0;
        for (int k = 0; k < 12; k++) begin
            if (div_clk === 1'b1) h++;
            @(negedge clk);
        end
        check("R5 hi==val constant high", h, 12);

        // R8: ratio change in mid-period
        do_reset();
        wr(5, 2);
        wait_high();
        cfg_we = 1'b1;
        cfg_div = 8'd2;
        cfg_high = 8'd0;
        @(negedge clk);
        cfg_we = 1'b0;
        measure(2, h, p);
        check("R8 old high kept", h, 3);
        check("R8 old period kept", p, 6);
        measure(1, h, p);
        check("R8 new high", h, 1);
        check("R8 new period", p, 3);

        // R3 and R8: stop request in mid-period
        do_reset();
        wr(5, 2);
        wait_high();
        cfg_we = 1'b1;
        cfg_div = 8'd0;
        cfg_high = 8'd0;
        @(negedge clk);
        cfg_we = 1'b0;
        check("R2 status after stop", int'(div_enabled), 0);
        h = 1;
        while (div_clk === 1'b1 && h < 50) begin
            h++;
            @(negedge clk);
        end
        check("R8 stop finishes high phase", h, 3);
        p = 0;
        for (int k = 0; k < 40; k++) begin
            if (div_clk !== 1'b0) p++;
            @(negedge clk);
        end
        check("R3 gated output stays low", p, 0);

        // R9: restart from stopped state, high phase first
        wr(2, 0);
        @(negedge clk);
        check("R9 restart low one edge later", int'(div_clk), 0);
        @(negedge clk);
        check("R9 restart high", int'(div_clk), 1);
        measure(1, h, p);
        check("R4 restart period", p, 3);

        // R1: reset while running
        wr(3, 1);
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset mid-run status", int'(div_enabled), 0);
        check("R1 reset mid-run output", int'(div_clk), 0);
        p = 0;
        for (int k = 0; k < 10; k++) begin
            if (div_clk !== 1'b0) p++;
            @(negedge clk);
        end
        check("R1 stays gated after reset", p, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule